// File: doc/BRIEF.md
# Eight-Bit Accumulator-Style ALU

This block is the arithmetic and logic core that a small accumulator processor uses. It takes two 8-bit operands, a carry input and a 3-bit operation code. It returns an 8-bit result together with zero, negative, carry and overflow flags.

The available operations are bitwise OR, AND and XOR, add with carry, and subtract with borrow. In subtract, the carry input counts as "no borrow". There is also a one-bit rotate through the carry, and bit 0 of the second operand selects its direction. The two unused codes pass the first operand straight through.

The result path is purely combinational. The clock and active-low reset ports are there only so the block fits a clocked pipeline and its embedded checks. The surrounding processor owns the accumulator, the flag register and instruction decoding.

Top module: `alu8_core`

## Requirements
- R1: Operation codes 0, 1 and 2 give `op_a | op_b`, `op_a & op_b` and `op_a ^ op_b` respectively, with carry and overflow flags at 0.
- R2: Code 3 gives the low 8 bits of `op_a + op_b + carry_in`, and the carry flag is the ninth bit of that sum.
- R3: For code 3, the overflow flag is 1 exactly when both operands have the same bit 7 and the result's bit 7 differs from it.
- R4: Code 4 gives the low 8 bits of `op_a - op_b - 1 + carry_in`. The carry flag is 1 exactly when no borrow occurs, that is when `op_a >= op_b + 1 - carry_in` (unsigned).
- R5: For code 4, the overflow flag is 1 exactly when the operands' bit 7 values differ and the result's bit 7 differs from `op_a` bit 7.
- R6: Code 5 with `op_b` bit 0 = 0 rotates `op_a` left through carry: `carry_in` enters bit 0 and `op_a` bit 7 becomes the carry flag. Bits 7..1 of `op_b` have no effect. Overflow is 0.
- R7: Code 5 with `op_b` bit 0 = 1 rotates `op_a` right through carry: `carry_in` enters bit 7 and `op_a` bit 0 becomes the carry flag. Overflow is 0.
- R8: Codes 6 and 7 return `op_a` unchanged, with carry and overflow at 0.
- R9: The zero flag is 1 exactly when the 8-bit result is 0x00, and the negative flag equals result bit 7, for every operation.
- R10: The result and all flags follow an input change within the same clock cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, used only by the embedded checks |
| rst_n | input | 1 | Active-low reset, disables the embedded checks |
| op_a | input | 8 | First operand |
| op_b | input | 8 | Second operand; bit 0 also sets rotate direction |
| carry_in | input | 1 | Carry input (acts as not-borrow in subtract) |
| op_sel | input | 3 | Operation code |
| result | output | 8 | Operation result |
| flag_zero | output | 1 | Result is all zeros |
| flag_neg | output | 1 | Result bit 7 |
| flag_carry | output | 1 | Carry out / not-borrow / rotated-out bit |
| flag_ovf | output | 1 | Signed overflow for add and subtract |

## Verification
The block holds no state, so an internal fault shows up at the ports in the same cycle as the stimulus that exposes it. Examples are a broken link in the carry chain, an inverted operand in subtract, or a wrong rotate direction. A carry-chain fault corrupts only those operand pairs whose carries ripple through the broken position. For that reason the vectors combine carry-propagating boundary values, such as 0xFF + 0x01 and 0x7F + 0x01, with a long run of random operands. A fault in the rotate direction or in the carry-as-not-borrow polarity shows up only for one value of `op_b` bit 0 or `carry_in`, so every operation is driven with both carry-in values.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

   typedef enum logic [2:0] {
      OP_OR   = 3'd0,
      OP_AND  = 3'd1,
      OP_XOR  = 3'd2,
      OP_ADC  = 3'd3,
      OP_SBC  = 3'd4,
      OP_ROT  = 3'd5,
      OP_THR6 = 3'd6,
      OP_THR7 = 3'd7
   } alu_op_e;

endpackage

// File: rtl/alu8_bitwise.sv
module alu8_bitwise
   import alu8_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  alu_op_e      op,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] y
);

   generate
      if (W < 1) begin : g_bad_width
         $error("alu8_bitwise: W must be at least 1");
      end
   endgenerate

   // one slice per bit; the opcode steers every slice the same way
   for (genvar i = 0; i < W; i++) begin : g_slice
      assign y[i] = (op == OP_AND) ? (a[i] & b[i]) :
                    (op == OP_XOR) ? (a[i] ^ b[i]) :
                                     (a[i] | b[i]);
   end

   // R1: AND never sets a bit that OR leaves clear
   p_and_within_or_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_AND) |-> ((y & ~(a | b)) == '0));

   // R1: XOR result has no bit common to both operands
   p_xor_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_XOR) |-> ((y & a & b) == '0));

endmodule

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
   parameter int W      = 8,
   parameter bit RIPPLE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sub,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         cout,
   output logic         ovf
);

   localparam int MSB = W - 1;

   logic [W-1:0] b_eff;

   generate
      if (W < 2) begin : g_bad_width
         $error("alu8_addsub: W must be at least 2");
      end
   endgenerate

   // subtract is a + ~b + cin, so cin reads as "no borrow"
   assign b_eff = sub ? ~b : b;

   generate
      if (RIPPLE) begin : g_ripple
         logic [W:0] chain;
         assign chain[0] = cin;
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign sum[i]     = a[i] ^ b_eff[i] ^ chain[i];
            assign chain[i+1] = (a[i] & b_eff[i]) | (chain[i] & (a[i] ^ b_eff[i]));
         end
         assign cout = chain[W];
      end else begin : g_behav
         logic [W:0] full;
         assign full = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
         assign sum  = full[W-1:0];
         assign cout = full[W];
      end
   endgenerate

   // signed overflow: effective operands agree in sign, result does not
   assign ovf = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);

   // R2: add result and carry match a wide unsigned sum
   p_add_sum_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !sub |-> ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin})));

   // R3: operands of opposite sign can never overflow on add
   p_add_no_ovf_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!sub && (a[MSB] != b[MSB])) |-> !ovf);

   // R4: carry out is the not-borrow condition
   p_sub_borrow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      sub |-> (cout == ({1'b0, a} >= ({1'b0, b} + {{W{1'b0}}, ~cin}))));

   // R5: operands of equal sign can never overflow on subtract
   p_sub_no_ovf_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sub && (a[MSB] == b[MSB])) |-> !ovf);

endmodule

// File: rtl/alu8_rotate.sv
module alu8_rotate #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         dir_right,
   input  logic [W-1:0] a,
   input  logic         cin,
   output logic [W-1:0] y,
   output logic         cout
);

   generate
      if (W < 2) begin : g_bad_width
         $error("alu8_rotate: W must be at least 2");
      end
   endgenerate

   always_comb begin
      if (dir_right) begin
         y    = {cin, a[W-1:1]};
         cout = a[0];
      end else begin
         y    = {a[W-2:0], cin};
         cout = a[W-1];
      end
   end

   // R6: a rotate through carry preserves the number of set bits
   p_rot_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({cout, y}) == $countones({cin, a}));

   // R6: left rotation keeps the operand's low bits shifted up by one
   p_rot_left_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !dir_right |-> (y[W-1:1] == a[W-2:0]));

   // R7: right rotation keeps the operand's high bits shifted down by one
   p_rot_right_r7: assert property (@(posedge clk) disable iff (!rst_n)
      dir_right |-> (y[W-2:0] == a[W-1:1]));

endmodule

// File: rtl/alu8_core.sv
module alu8_core
   import alu8_pkg::*;
#(
   parameter int WIDTH        = 8,
   parameter bit RIPPLE_ADDER = 1'b1,
   parameter int ROT_DIR_BIT  = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic             carry_in,
   input  logic [2:0]       op_sel,
   output logic [WIDTH-1:0] result,
   output logic             flag_zero,
   output logic             flag_neg,
   output logic             flag_carry,
   output logic             flag_ovf
);

   localparam int MSB = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("alu8_core: WIDTH must be at least 2");
      end
      if (ROT_DIR_BIT < 0 || ROT_DIR_BIT >= WIDTH) begin : g_bad_dir
         $error("alu8_core: ROT_DIR_BIT must index op_b");
      end
   endgenerate

   alu_op_e          op;
   logic [WIDTH-1:0] logic_y;
   logic [WIDTH-1:0] arith_y;
   logic             arith_c;
   logic             arith_v;
   logic [WIDTH-1:0] rot_y;
   logic             rot_c;

   assign op = alu_op_e'(op_sel);

   alu8_bitwise #(.W(WIDTH)) u_bitwise (
      .clk (clk),
      .rst_n(rst_n),
      .op  (op),
      .a   (op_a),
      .b   (op_b),
      .y   (logic_y)
   );

   alu8_addsub #(.W(WIDTH), .RIPPLE(RIPPLE_ADDER)) u_addsub (
      .clk  (clk),
      .rst_n(rst_n),
      .sub  (op == OP_SBC),
      .a    (op_a),
      .b    (op_b),
      .cin  (carry_in),
      .sum  (arith_y),
      .cout (arith_c),
      .ovf  (arith_v)
   );

   alu8_rotate #(.W(WIDTH)) u_rotate (
      .clk      (clk),
      .rst_n    (rst_n),
      .dir_right(op_b[ROT_DIR_BIT]),
      .a        (op_a),
      .cin      (carry_in),
      .y        (rot_y),
      .cout     (rot_c)
   );

   always_comb begin
      result     = op_a;
      flag_carry = 1'b0;
      flag_ovf   = 1'b0;
      unique case (op)
         OP_OR, OP_AND, OP_XOR: result = logic_y;
         OP_ADC, OP_SBC: begin
            result     = arith_y;
            flag_carry = arith_c;
            flag_ovf   = arith_v;
         end
         OP_ROT: begin
            result     = rot_y;
            flag_carry = rot_c;
         end
         default: result = op_a;
      endcase
   end

   assign flag_zero = ~|result;
   assign flag_neg  = result[MSB];

   // R1: logic operations leave carry and overflow clear
   p_logic_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel <= 3'd2) |-> (!flag_carry && !flag_ovf));

   // R8: unused codes pass op_a through with flags clear
   p_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel >= 3'd6) |-> (result == op_a && !flag_carry && !flag_ovf));

   // R9: a zero result is never negative
   p_zero_neg_r9: assert property (@(posedge clk) disable iff (!rst_n)
      flag_zero |-> !flag_neg);

   // R6: rotate never reports overflow
   p_rot_no_ovf_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == 3'd5) |-> !flag_ovf);

endmodule

// File: tb/alu8_core_tb_top.sv
module alu8_core_tb_top;

   localparam int CLK_PERIOD = 10;

   typedef struct {
      string      tag;
      logic [7:0] a, b;
      logic       c;
      logic [2:0] s;
      logic [7:0] r;
      logic       co, v, z, n;
   } item_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] op_a = '0, op_b = '0;
   logic       carry_in = 1'b0;
   logic [2:0] op_sel = '0;
   logic [7:0] result;
   logic       flag_zero, flag_neg, flag_carry, flag_ovf;

   item_t q[$];
   int    n_vec  = 0;
   int    n_fail = 0;
   bit    done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   alu8_core dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .op_a      (op_a),
      .op_b      (op_b),
      .carry_in  (carry_in),
      .op_sel    (op_sel),
      .result    (result),
      .flag_zero (flag_zero),
      .flag_neg  (flag_neg),
      .flag_carry(flag_carry),
      .flag_ovf  (flag_ovf)
   );

   // reference model written from the requirements
   function automatic item_t model(string tag, logic [7:0] a, logic [7:0] b,
                                   logic c, logic [2:0] s);
      item_t it;
      int ua, ub, ci, sa, sb, t, st;
      ua = int'(a); ub = int'(b); ci = int'(c);
      sa = int'($signed(a)); sb = int'($signed(b));
      it.tag = tag; it.a = a; it.b = b; it.c = c; it.s = s;
      it.co = 1'b0; it.v = 1'b0; it.r = a;
      case (s)
         3'd0: it.r = a | b;
         3'd1: it.r = a & b;
         3'd2: it.r = a ^ b;
         3'd3: begin
            t = ua + ub + ci; it.r = 8'(t); it.co = (t > 255);
            st = sa + sb + ci; it.v = (st > 127) || (st < -128);
         end
         3'd4: begin
            t = ua - ub - 1 + ci; it.r = 8'(t); it.co = (ua >= ub + 1 - ci);
            st = sa - sb - 1 + ci; it.v = (st > 127) || (st < -128);
         end
         3'd5: begin
            if (!b[0]) begin it.r = {a[6:0], c}; it.co = a[7]; end
            else       begin it.r = {c, a[7:1]}; it.co = a[0]; end
         end
         default: it.r = a;
      endcase
      it.z = (it.r == 8'h00);
      it.n = it.r[7];
      return it;
   endfunction

   // driver: drive just after the rising edge, push the expectation
   task automatic drive(string tag, logic [7:0] a, logic [7:0] b, logic c, logic [2:0] s);
      @(posedge clk);
      #1;
      op_a = a; op_b = b; carry_in = c; op_sel = s;
      q.push_back(model(tag, a, b, c, s));
   endtask

   // monitor: compare at the falling edge, same cycle as the drive (R10)
   always @(negedge clk) begin
      if (q.size() > 0) begin
         item_t e;
         e = q.pop_front();
         n_vec++;
         if (result !== e.r || flag_carry !== e.co || flag_ovf !== e.v ||
             flag_zero !== e.z || flag_neg !== e.n) begin
            n_fail++;
            $display("FAIL %s (R10 same-cycle) a=%h b=%h c=%b sel=%0d: got r=%h c=%b v=%b z=%b n=%b, expected r=%h c=%b v=%b z=%b n=%b",
                     e.tag, e.a, e.b, e.c, e.s, result, flag_carry, flag_ovf,
                     flag_zero, flag_neg, e.r, e.co, e.v, e.z, e.n);
         end
      end
   end

   function automatic string tag_of(logic [2:0] s, logic [7:0] b);
      case (s)
         3'd0, 3'd1, 3'd2: return "R1";
         3'd3: return "R2/R3";
         3'd4: return "R4/R5";
         3'd5: return b[0] ? "R7" : "R6";
         default: return "R8";
      endcase
   endfunction

   initial begin
      // reset state: all-zero inputs, OR -> zero result (R9)
      drive("R9 reset", 8'h00, 8'h00, 1'b0, 3'd0);
      drive("R9 reset", 8'h00, 8'h00, 1'b0, 3'd0);
      rst_n = 1'b1;
      // R1 logic
      drive("R1", 8'h11, 8'h22, 1'b0, 3'd0);
      drive("R1", 8'h11, 8'h22, 1'b1, 3'd1);
      drive("R1", 8'h11, 8'h22, 1'b1, 3'd2);
      drive("R1 R9", 8'h22, 8'h22, 1'b0, 3'd2);
      drive("R1 R9", 8'hA5, 8'h0F, 1'b1, 3'd1);
      // R2 / R3 add
      drive("R2", 8'h22, 8'h22, 1'b0, 3'd3);
      drive("R2", 8'h22, 8'h22, 1'b1, 3'd3);
      drive("R2", 8'hF0, 8'h10, 1'b0, 3'd3);
      drive("R2 R9", 8'hFF, 8'h00, 1'b1, 3'd3);
      drive("R3", 8'h7F, 8'h01, 1'b0, 3'd3);
      drive("R3", 8'h80, 8'h80, 1'b0, 3'd3);
      drive("R3", 8'h7F, 8'h00, 1'b1, 3'd3);
      drive("R3", 8'h80, 8'h7F, 1'b1, 3'd3);
      // R4 / R5 subtract
      drive("R4", 8'hF0, 8'h10, 1'b0, 3'd4);
      drive("R4", 8'hF0, 8'h10, 1'b1, 3'd4);
      drive("R4 R9", 8'h10, 8'h10, 1'b1, 3'd4);
      drive("R4", 8'h10, 8'h10, 1'b0, 3'd4);
      drive("R4", 8'h00, 8'hFF, 1'b1, 3'd4);
      drive("R5", 8'h80, 8'h01, 1'b1, 3'd4);
      drive("R5", 8'h7F, 8'hFF, 1'b1, 3'd4);
      drive("R5", 8'h80, 8'h00, 1'b0, 3'd4);
      // R6 / R7 rotate
      drive("R6", 8'hF0, 8'h00, 1'b1, 3'd5);
      drive("R6", 8'hF0, 8'h00, 1'b0, 3'd5);
      drive("R6 ignored b", 8'h81, 8'hFE, 1'b0, 3'd5);
      drive("R6 R9", 8'h80, 8'h00, 1'b0, 3'd5);
      drive("R7", 8'hF0, 8'h01, 1'b0, 3'd5);
      drive("R7", 8'hF1, 8'h01, 1'b1, 3'd5);
      drive("R7 ignored b", 8'h01, 8'hFF, 1'b0, 3'd5);
      // R8 pass-through
      drive("R8", 8'h9C, 8'h55, 1'b1, 3'd6);
      drive("R8", 8'h00, 8'hFF, 1'b1, 3'd7);
      // random sweep over every op and carry-in
      for (int i = 0; i < 2000; i++) begin
         logic [7:0] ra, rb;
         logic [2:0] rs;
         ra = 8'($urandom); rb = 8'($urandom); rs = 3'($urandom);
         drive(tag_of(rs, rb), ra, rb, 1'($urandom), rs);
      end
      @(posedge clk);
      @(posedge clk);
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         done = 1'b1;
         n_fail++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end

endmodule